// File: doc/BRIEF.md
# Shared TDM Slot Driver Arbiter

This block lives inside a host-interface controller that shares one time-division-multiplexed serial data line with a DSP. Both may send words to a codec in the same command and playback slots, but never in the same slot at the same time. The block follows the frame from the bit-rate strobe and the frame sync, and counts 16-bit slots in a 32-slot frame. For every slot it decides whether the controller's serial output driver is enabled or left at high impedance.

A mode input chooses whether the host or the DSP owns the codec command and playback slots. These are positions 0 to 2 of each half-frame, so slots 0-2 and 16-18. The controller always drives a DSP control word at position 6 of each half-frame, slots 6 and 22. The bit it outputs for that word tells the DSP to release the codec slots (1) or to keep them (0). The requested mode is taken only at a frame sync. When ownership moves from the DSP to the host, the host's codec drivers wait out a guard interval first. The controller loads each transmit word on a strobe during the first bit of each slot it drives.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: While and right after reset, slot_num is 0 and drv_oe, word_load, ctrl_slot, release_cmd and host_owns are all 0.
- R2: A clock with bit_en=1 and fsync=1 puts the slot and the bit position at 0. fsync while bit_en=0 has no effect on slot_num.
- R3: slot_num holds while bit_en=0. It advances by one after every 16 bit_en strobes, and wraps from 31 to 0 even when no frame sync arrives.
- R4: Until the first accepted frame sync, drv_oe and ctrl_slot stay 0.
- R5: Once synchronised, in slots 6 and 22 (half-frame position 6) ctrl_slot=1 and drv_oe=1 in both modes.
- R6: In host mode with the guard elapsed, drv_oe=1 in slots 0-2 and 16-18.
- R7: In DSP mode, drv_oe=0 in slots 0-2 and 16-18.
- R8: drv_oe is 0 in every slot other than 0-2, 6, 16-18 and 22. This includes the unused slots 12-15 and 28-31.
- R9: dsp_mode (1 = DSP owns, 0 = host owns) is sampled only on a clock with bit_en=1 and fsync=1. Changes at other times have no effect until then.
- R10: release_cmd is 1 while the frame's mode is host and 0 while it is DSP. It changes only at an accepted frame sync.
- R11: After a frame sync that switches from DSP to host, host_owns and the codec-slot drv_oe stay 0 for the rest of that frame and for one further full frame. A switch from host to DSP takes effect at once.
- R12: word_load is 1 exactly when drv_oe is 1 and the current bit position within the slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-clock strobe per serial bit |
| fsync | input | 1 | Frame sync, qualified by bit_en, marks bit 0 of slot 0 |
| dsp_mode | input | 1 | Requested owner of codec slots: 1 DSP, 0 host |
| slot_num | output | 5 | Current slot number |
| drv_oe | output | 1 | Controller serial driver enable for this slot |
| word_load | output | 1 | Load strobe for the slot's transmit word |
| ctrl_slot | output | 1 | Current slot carries the DSP control word |
| release_cmd | output | 1 | Release bit for the DSP control word |
| host_owns | output | 1 | Host currently drives the codec slots |

## Verification
The bench uses the default parameters: 16-bit slots, 32 slots per frame, codec slots at half-frame positions 0-2, the control word at position 6, and a one-frame guard. With these values both half-frames, the unused tail slots and the 31-to-0 wrap all occur within a few thousand bit strobes. Short frames cut off by an early sync, and frames that run on without a sync, are also reachable. The guard expiry takes two frames, so a run of mode schedules can cover host entry, a host-to-DSP switch while the guard is still counting, and mid-frame mode toggles that must be ignored.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;
  typedef enum logic {
    OWN_DSP  = 1'b0,
    OWN_HOST = 1'b1
  } owner_e;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int SLOT_BITS = 16,
  parameter int SLOTS     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_en,
  input  logic                       fsync,
  output logic [$clog2(SLOTS)-1:0]     slot_o,
  output logic [$clog2(SLOT_BITS)-1:0] bit_o,
  output logic                       frame_tick_o
);
  localparam int BW = $clog2(SLOT_BITS);
  localparam int SW = $clog2(SLOTS);
  localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_BITS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

  logic [BW-1:0] bit_q, bit_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          tick;

  assign tick = bit_en & fsync;

  always_comb begin
    bit_d  = bit_q;
    slot_d = slot_q;
    if (tick) begin
      bit_d  = '0;
      slot_d = '0;
    end else if (bit_en) begin
      if (bit_q == BIT_LAST) begin
        bit_d  = '0;
        slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end

  assign slot_o       = slot_q;
  assign bit_o        = bit_q;
  assign frame_tick_o = tick;
endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map #(
  parameter int SLOTS         = 32,
  parameter int HALF          = 16,
  parameter int CODEC_FIRST   = 0,
  parameter int CODEC_COUNT   = 3,
  parameter int CTRL_POS      = 6,
  parameter int USED_PER_HALF = 12
) (
  input  logic [$clog2(SLOTS)-1:0] slot_i,
  output logic                     is_codec_o,
  output logic                     is_ctrl_o
);
  logic [SLOTS-1:0] codec_map;
  logic [SLOTS-1:0] ctrl_map;

  // One decode bit per slot, built from its position inside its half-frame.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int POS = s % HALF;
    assign codec_map[s] = (POS >= CODEC_FIRST) && (POS < CODEC_FIRST + CODEC_COUNT)
                          && (POS < USED_PER_HALF);
    assign ctrl_map[s]  = (POS == CTRL_POS) && (POS < USED_PER_HALF);
  end

  assign is_codec_o = codec_map[slot_i];
  assign is_ctrl_o  = ctrl_map[slot_i];
endmodule

// File: rtl/tdm_own_ctrl.sv
module tdm_own_ctrl
  import tdm_arb_pkg::*;
#(
  parameter int GUARD_FRAMES = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_tick,
  input  logic   dsp_req,
  output owner_e owner_o,
  output logic   guard_clear_o,
  output logic   synced_o
);
  localparam int GW = $clog2(GUARD_FRAMES + 2);
  localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_FRAMES + 1);

  owner_e        owner_q, owner_d;
  logic [GW-1:0] guard_q, guard_d;
  logic          synced_q, synced_d;
  owner_e        req_owner;

  assign req_owner = dsp_req ? OWN_DSP : OWN_HOST;

  always_comb begin
    owner_d  = owner_q;
    guard_d  = guard_q;
    synced_d = synced_q;
    if (frame_tick) begin
      synced_d = 1'b1;
      owner_d  = req_owner;
      if (owner_q == OWN_DSP && req_owner == OWN_HOST) begin
        guard_d = GUARD_LOAD;
      end else if (guard_q != '0) begin
        guard_d = guard_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_DSP;
      guard_q  <= '0;
      synced_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      guard_q  <= guard_d;
      synced_q <= synced_d;
    end
  end

  assign owner_o       = owner_q;
  assign guard_clear_o = (guard_q == '0);
  assign synced_o      = synced_q;
endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter
  import tdm_arb_pkg::*;
#(
  parameter int SLOT_BITS     = 16,
  parameter int SLOTS         = 32,
  parameter int CODEC_FIRST   = 0,
  parameter int CODEC_COUNT   = 3,
  parameter int CTRL_POS      = 6,
  parameter int USED_PER_HALF = 12,
  parameter int GUARD_FRAMES  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic                     fsync,
  input  logic                     dsp_mode,
  output logic [$clog2(SLOTS)-1:0] slot_num,
  output logic                     drv_oe,
  output logic                     word_load,
  output logic                     ctrl_slot,
  output logic                     release_cmd,
  output logic                     host_owns
);
  localparam int HALF = SLOTS / 2;
  localparam int BW   = $clog2(SLOT_BITS);
  localparam int SW   = $clog2(SLOTS);

  logic [SW-1:0] slot;
  logic [BW-1:0] bitpos;
  logic          frame_tick;
  logic          is_codec, is_ctrl;
  owner_e        owner;
  logic          guard_clear, synced;

  tdm_slot_counter #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .fsync        (fsync),
    .slot_o       (slot),
    .bit_o        (bitpos),
    .frame_tick_o (frame_tick)
  );

  tdm_slot_map #(
    .SLOTS(SLOTS), .HALF(HALF), .CODEC_FIRST(CODEC_FIRST),
    .CODEC_COUNT(CODEC_COUNT), .CTRL_POS(CTRL_POS), .USED_PER_HALF(USED_PER_HALF)
  ) u_map (
    .slot_i     (slot),
    .is_codec_o (is_codec),
    .is_ctrl_o  (is_ctrl)
  );

  tdm_own_ctrl #(.GUARD_FRAMES(GUARD_FRAMES)) u_own (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_tick    (frame_tick),
    .dsp_req       (dsp_mode),
    .owner_o       (owner),
    .guard_clear_o (guard_clear),
    .synced_o      (synced)
  );

  logic host_active;
  assign host_active = synced & (owner == OWN_HOST) & guard_clear;

  assign slot_num    = slot;
  assign host_owns   = host_active;
  assign release_cmd = (owner == OWN_HOST);
  assign ctrl_slot   = synced & is_ctrl;
  assign drv_oe      = synced & (is_ctrl | (is_codec & host_active));
  assign word_load   = drv_oe & (bitpos == '0);
endmodule

// File: rtl/tdm_slot_arbiter_chk.sv
module tdm_slot_arbiter_chk #(
  parameter int SLOTS       = 32,
  parameter int CODEC_FIRST = 0,
  parameter int CODEC_COUNT = 3,
  parameter int CTRL_POS    = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bit_en,
  input logic                     fsync,
  input logic                     dsp_mode,
  input logic [$clog2(SLOTS)-1:0] slot_num,
  input logic                     drv_oe,
  input logic                     word_load,
  input logic                     ctrl_slot,
  input logic                     release_cmd,
  input logic                     host_owns
);
  localparam int HW = $clog2(SLOTS / 2);

  logic [HW-1:0] pos;
  logic          in_codec;
  assign pos      = slot_num[HW-1:0];
  assign in_codec = (HW'(pos - HW'(CODEC_FIRST)) < HW'(CODEC_COUNT));

  // R8
  unused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> (in_codec || pos == HW'(CTRL_POS)));
  // R7
  dsp_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!release_cmd && in_codec) |-> !drv_oe);
  // R12
  load_in_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |-> drv_oe);
  // R5
  ctrl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_slot |-> drv_oe);
  // R10
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && fsync) |=> $stable(release_cmd));
  // R9
  mode_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> (release_cmd == !$past(dsp_mode)));
  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> (slot_num == '0));
  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(slot_num));
  // R11
  guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_cmd) |-> !host_owns);
endmodule

bind tdm_slot_arbiter tdm_slot_arbiter_chk #(
  .SLOTS(SLOTS), .CODEC_FIRST(CODEC_FIRST), .CODEC_COUNT(CODEC_COUNT), .CTRL_POS(CTRL_POS)
) u_chk (.*);

// File: tb/tb_tdm_slot_arbiter.sv
module tb_tdm_slot_arbiter;
  localparam int SLOT_BITS = 16;
  localparam int SLOTS     = 32;
  localparam int HALF      = 16;
  localparam int GUARD     = 1;

  logic       clk;
  logic       rst_n;
  logic       bit_en;
  logic       fsync;
  logic       dsp_mode;
  logic [4:0] slot_num;
  logic       drv_oe, word_load, ctrl_slot, release_cmd, host_owns;

  int checks;
  int errors;
  bit finished;

  // bench model of the requirements
  int m_slot, m_bit, m_guard;
  bit m_dsp, m_sync;

  tdm_slot_arbiter dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .dsp_mode(dsp_mode),
    .slot_num(slot_num), .drv_oe(drv_oe), .word_load(word_load),
    .ctrl_slot(ctrl_slot), .release_cmd(release_cmd), .host_owns(host_owns)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (slot %0d bit %0d)",
               tag, what, act, exp, m_slot, m_bit);
    end
  endtask

  function automatic bit f_codec(int s);
    return (s % HALF) < 3;
  endfunction
  function automatic bit f_ctrl(int s);
    return (s % HALF) == 6;
  endfunction
  function automatic bit f_host();
    return m_sync && !m_dsp && (m_guard == 0);
  endfunction
  function automatic bit f_oe();
    return m_sync && (f_ctrl(m_slot) || (f_codec(m_slot) && f_host()));
  endfunction
  function automatic string f_oe_tag();
    if (!m_sync) return "R4";
    if (f_ctrl(m_slot)) return "R5";
    if (f_codec(m_slot)) begin
      if (m_dsp) return "R7";
      if (m_guard != 0) return "R11";
      return "R6";
    end
    return "R8";
  endfunction

  task automatic model_step(input bit be, input bit fs, input bit md);
    if (be) begin
      if (fs) begin
        m_bit  = 0;
        m_slot = 0;
        m_sync = 1;
        if (m_dsp && !md) m_guard = GUARD + 1;
        else if (m_guard > 0) m_guard--;
        m_dsp = md;
      end else if (m_bit == SLOT_BITS - 1) begin
        m_bit  = 0;
        m_slot = (m_slot + 1) % SLOTS;
      end else begin
        m_bit++;
      end
    end
  endtask

  task automatic compare_all(input bit fs_tick);
    chk(fs_tick ? "R2" : "R3", "slot_num", int'(slot_num), m_slot);
    chk(f_oe_tag(), "drv_oe", int'(drv_oe), int'(f_oe()));
    chk("R12", "word_load", int'(word_load), int'(f_oe() && m_bit == 0));
    chk("R5", "ctrl_slot", int'(ctrl_slot), int'(m_sync && f_ctrl(m_slot)));
    chk("R10 (R9)", "release_cmd", int'(release_cmd), int'(!m_dsp));
    chk("R11", "host_owns", int'(host_owns), int'(f_host()));
  endtask

  task automatic tick(input bit be, input bit fs, input bit md);
    @(negedge clk);
    bit_en   = be;
    fsync    = fs;
    dsp_mode = md;
    @(posedge clk);
    model_step(be, fs, md);
    #5;
    compare_all(be && fs);
  endtask

  bit cur_md;

  // one frame: fsync with the planned mode, then nbits-1 more bits,
  // idle gaps and mid-frame mode toggles mixed in
  task automatic run_frame(input int nbits, input bit mode);
    cur_md = mode;
    tick(1'b1, 1'b1, cur_md);
    for (int i = 1; i < nbits; i++) begin
      if (($urandom % 3) == 0) tick(1'b0, ($urandom % 4) == 0, cur_md);
      if (($urandom % 64) == 0) cur_md = ~cur_md;   // R9: must be ignored
      tick(1'b1, 1'b0, cur_md);
    end
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    void'($urandom(32'd1847));
    m_slot = 0; m_bit = 0; m_guard = 0; m_dsp = 1; m_sync = 0;
    rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; dsp_mode = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    // R1: reset state
    chk("R1", "slot_num", int'(slot_num), 0);
    chk("R1", "drv_oe", int'(drv_oe), 0);
    chk("R1", "word_load", int'(word_load), 0);
    chk("R1", "ctrl_slot", int'(ctrl_slot), 0);
    chk("R1", "release_cmd", int'(release_cmd), 0);
    chk("R1", "host_owns", int'(host_owns), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: bits before any frame sync, including through slot 6
    for (int i = 0; i < 120; i++) tick(1'b1, 1'b0, 1'($urandom % 2));
    // R2: fsync without bit_en is ignored
    tick(1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b1);

    // short frame cut by an early sync (R2), then a mode schedule
    run_frame(100, 1'b1);
    run_frame(512, 1'b1);
    run_frame(512, 1'b0);   // switch to host: guard frame
    run_frame(512, 1'b0);   // guard still running (R11)
    run_frame(512, 1'b0);   // host drives (R6)
    run_frame(512, 1'b1);   // host to DSP at once (R7)
    run_frame(512, 1'b0);
    run_frame(300, 1'b1);   // host to DSP while guard counting
    run_frame(512, 1'b0);
    run_frame(512, 1'b0);
    run_frame(700, 1'b0);   // runs past slot 31 without sync: wrap (R3)
    run_frame(512, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule